// File: doc/BRIEF.md
# Performance Counter Bank with Central Enable and Freeze

This block holds a small bank of event counters for performance monitoring. Each counter advances by one on any clock in which its own increment input is high, its enable bit is set and the external freeze input is low. All enable bits sit side by side in one central register, so a single register write starts or stops every counter on the same clock edge. Each counter also has its own control register whose bit 0 is a second view of that same enable bit. Counters belong to no privilege level: software decides what each one counts.

A counter reports overflow when it steps from 0x7F..F to 0x80..0. Its full value therefore stays readable as one unsigned word. Overflow sets a sticky status bit for that counter. A single interrupt request is raised while any sticky bit is set and its interrupt mask bit is set. The freeze input lets logic outside the chip halt every counter at once without touching the enable bits.

Software reaches the block through a plain register port: an address, a write strobe and write data, with read data that follows the address in the same cycle. The register port and the event inputs are control signals with no back-pressure. No valid/ready stream is involved.

Top module: `pmc_bank`

## Requirements
- R1: While `rst_n` is low, every counter, enable bit, interrupt mask bit and sticky bit is zero, and `irq_o` is low.
- R2: The enable register at address 0x00 holds counter i's enable in bit i. One write there sets every enable bit on the same edge, so all counters start or stop together.
- R3: Bit 0 of the control register at address 0x20+i is the same storage as bit i of address 0x00. A write there changes only counter i's enable, and both views always read the same value. All other bits of the control register read as 0.
- R4: The counter at address 0x10+i adds 1 on each edge where `inc_i[i]`, its enable bit and not `freeze_i` are all true. The new value is readable after that edge.
- R5: While `freeze_i` is high, no counter increments, whatever the enable bits hold. The enable register is left unchanged.
- R6: A write to address 0x10+i loads the low counter-width bits of `reg_wdata` into counter i. The write wins over an increment in the same cycle.
- R7: Bit i of the status register at address 0x01 is set when an increment takes counter i from 0x7F..F to 0x80..0. A wrap from all-ones to zero does not set it, and neither does a software load.
- R8: A status bit is cleared only by a write to address 0x01 with a 1 in that bit position. A 0 in that position leaves the bit unchanged. If a clear and a new overflow for the same bit fall on the same edge, the bit stays set.
- R9: `irq_o` is high exactly while some status bit and the matching bit of the interrupt mask register at address 0x02 are both set. It rises in the cycle after the edge that sets the status bit, and it stays high until that bit is cleared or masked.
- R10: Reads from addresses that are not mapped return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | N_CTR | One increment request per counter |
| freeze_i | input | 1 | External freeze; blocks every increment |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Shared overflow interrupt request |

## Verification
Each write and each increment is sampled on a rising edge and shows up in the read data and status right after that edge. Read data follows the address within the same cycle, and `irq_o` rises one edge after the overflowing increment. The bench drives inputs 2 ns after a falling edge and compares the read data and `irq_o` on the next falling edge. By then exactly one rising edge has passed, and its reference model has taken that same edge into account. The directed steps that test freeze, write priority, overflow and clear-versus-set all finish with reads timed in that cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_EN   = 6'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h01;
  localparam logic [ADDR_W-1:0] A_IE   = 6'h02;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CTL  = 6'h20;

  function automatic logic [ADDR_W-1:0] cnt_addr(input int idx);
    return A_CNT + ADDR_W'(idx);
  endfunction

  function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
    return A_CTL + ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_val,
  input  logic          step,
  output logic [CW-1:0] value,
  output logic          msb_cross
);
  localparam logic [CW-1:0] HALF_M1 = {1'b0, {(CW-1){1'b1}}};

  // software load outranks counting
  assign msb_cross = !wr_hit && step && (value == HALF_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (wr_hit) value <= wr_val;
    else if (step)   value <= value + 1'b1;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      wr_val,
  input  logic [N-1:0]      ovf,
  output logic [N-1:0]      en,
  output logic [N-1:0]      ie,
  output logic [N-1:0]      sticky,
  output logic              irq
);
  logic [N-1:0] en_nx, clr;

  always_comb begin
    en_nx = en;
    if (reg_we) begin
      if (reg_addr == A_EN) en_nx = wr_val;
      for (int i = 0; i < N; i++)
        if (reg_addr == ctl_addr(i)) en_nx[i] = wr_val[0];
    end
  end

  assign clr = (reg_we && reg_addr == A_STAT) ? wr_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      ie     <= '0;
      sticky <= '0;
    end else begin
      en     <= en_nx;
      if (reg_we && reg_addr == A_IE) ie <= wr_val;
      sticky <= (sticky & ~clr) | ovf;
    end
  end

  assign irq = |(sticky & ie);
endmodule

// File: rtl/pmc_rdmux.sv
module pmc_rdmux
  import pmc_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      en,
  input  logic [N-1:0]      ie,
  input  logic [N-1:0]      sticky,
  input  logic [N*CW-1:0]   cnt_flat,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (addr == A_EN)   rdata[N-1:0] = en;
    if (addr == A_STAT) rdata[N-1:0] = sticky;
    if (addr == A_IE)   rdata[N-1:0] = ie;
    for (int i = 0; i < N; i++) begin
      if (addr == cnt_addr(i)) rdata[CW-1:0] = cnt_flat[i*CW +: CW];
      if (addr == ctl_addr(i)) rdata[0] = en[i];
    end
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int N_CTR  = 4,
  parameter int CTR_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CTR-1:0]  inc_i,
  input  logic              freeze_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [N_CTR-1:0]       en, ie, sticky, ovf, step;
  logic [N_CTR*CTR_W-1:0] cnt_flat;

  assign step = inc_i & en & {N_CTR{!freeze_i}};

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    logic hit;
    assign hit = reg_we && (reg_addr == cnt_addr(g));
    pmc_counter #(.CW(CTR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit),
      .wr_val    (reg_wdata[CTR_W-1:0]),
      .step      (step[g]),
      .value     (cnt_flat[g*CTR_W +: CTR_W]),
      .msb_cross (ovf[g])
    );
  end

  pmc_ctrl #(.N(N_CTR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wr_val   (reg_wdata[N_CTR-1:0]),
    .ovf      (ovf),
    .en       (en),
    .ie       (ie),
    .sticky   (sticky),
    .irq      (irq_o)
  );

  pmc_rdmux #(.N(N_CTR), .CW(CTR_W), .DW(DATA_W)) u_rd (
    .addr     (reg_addr),
    .en       (en),
    .ie       (ie),
    .sticky   (sticky),
    .cnt_flat (cnt_flat),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze_i,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              irq_o,
  input logic [N*CW-1:0]   cnt_flat,
  input logic [N-1:0]      sticky
);
  logic any_cnt_wr;
  assign any_cnt_wr = reg_we && (reg_addr >= A_CNT) && (reg_addr < cnt_addr(N));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt_flat == '0 && sticky == '0 && !irq_o));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !any_cnt_wr) |=> $stable(cnt_flat));

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STAT) |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reg_we) |=> irq_o);

  for (genvar g = 0; g < N; g++) begin : g_prop
    // R7
    msb_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky[g]) |-> ($past(cnt_flat[g*CW +: CW]) == {1'b0, {(CW-1){1'b1}}}));
    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == cnt_addr(g)) |=> (cnt_flat[g*CW +: CW] == $past(reg_wdata[CW-1:0])));
  end
endmodule

bind pmc_bank pmc_bank_chk #(.N(N_CTR), .CW(CTR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freeze_i  (freeze_i),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .cnt_flat  (cnt_flat),
  .sticky    (sticky)
);

// File: tb/pmc_bank_tb.sv
module pmc_bank_tb;
  localparam int N  = 4;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  inc = '0;
  logic          frz = 1'b0;
  logic          we = 1'b0;
  logic [5:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  string cur_tag = "";

  bit [CW-1:0] m_cnt [N];
  bit [N-1:0]  m_en, m_ie, m_st;

  always #10 clk = ~clk;

  pmc_bank #(.N_CTR(N), .CTR_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .freeze_i(frz),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq)
  );

  // reference model: advanced on each rising edge from the held inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
      m_en = '0; m_ie = '0; m_st = '0;
    end else begin
      bit [N-1:0] ov;
      bit [N-1:0] en_new;
      ov = '0;
      for (int i = 0; i < N; i++) begin
        if (we && addr == 6'h10 + 6'(i)) m_cnt[i] = wdata[CW-1:0];
        else if (inc[i] && m_en[i] && !frz) begin
          if (m_cnt[i] == (1 << (CW-1)) - 1) ov[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1'b1;
        end
      end
      en_new = m_en;
      if (we && addr == 6'h00) en_new = wdata[N-1:0];
      for (int i = 0; i < N; i++)
        if (we && addr == 6'h20 + 6'(i)) en_new[i] = wdata[0];
      m_en = en_new;
      if (we && addr == 6'h02) m_ie = wdata[N-1:0];
      if (we && addr == 6'h01) m_st = m_st & ~wdata[N-1:0];
      m_st = m_st | ov;
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [5:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a == 6'h00) r[N-1:0] = m_en;
    if (a == 6'h01) r[N-1:0] = m_st;
    if (a == 6'h02) r[N-1:0] = m_ie;
    for (int i = 0; i < N; i++) begin
      if (a == 6'h10 + 6'(i)) r[CW-1:0] = m_cnt[i];
      if (a == 6'h20 + 6'(i)) r[0] = m_en[i];
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [5:0] a);
    if (!rst_n) return "R1";
    if (cur_tag != "") return cur_tag;
    if (a == 6'h00) return "R2";
    if (a == 6'h01) return "R8";
    if (a == 6'h02) return "R9";
    if (a >= 6'h10 && a < 6'h10 + 6'(N)) return "R4";
    if (a >= 6'h20 && a < 6'h20 + 6'(N)) return "R3";
    return "R10";
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    logic [DW-1:0] e;
    e = exp_rd(addr);
    total++;
    if (rdata !== e) begin
      bad++;
      $display("FAIL %s rdata addr=%h act=%h exp=%h", tag_for(addr), addr, rdata, e);
    end
    total++;
    if (irq !== (|(m_st & m_ie))) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", rst_n ? "R9" : "R1", irq, |(m_st & m_ie));
    end
  end

  task automatic cyc(input logic [N-1:0] i_inc, input logic i_frz, input logic i_we,
                     input logic [5:0] i_a, input logic [DW-1:0] i_d);
    @(negedge clk);
    #2;
    inc = i_inc; frz = i_frz; we = i_we; addr = i_a; wdata = i_d;
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    cyc('0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [5:0] a);
    cyc('0, 1'b0, 1'b0, a, '0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    rd(6'h10); rd(6'h01);

    // R2 central enable, R4 counting
    wr(6'h00, 32'h5);
    for (int k = 0; k < 5; k++) cyc('1, 1'b0, 1'b0, 6'(6'h10 + 6'(k % 3)), '0);
    rd(6'h12);

    // R3 aliased per-counter view
    wr(6'h21, 32'h1);
    rd(6'h00); rd(6'h21); rd(6'h20);
    wr(6'h20, 32'hFFFE);
    rd(6'h00); rd(6'h20);

    // R5 freeze
    cur_tag = "R5";
    for (int k = 0; k < 4; k++) cyc('1, 1'b1, 1'b0, 6'h12, '0);
    cyc('1, 1'b1, 1'b0, 6'h00, '0);
    rd(6'h11);

    // R6 load beats increment
    cur_tag = "R6";
    cyc(4'b0100, 1'b0, 1'b1, 6'h12, 32'h1234);
    rd(6'h12);

    // R7 overflow on MSB crossing
    cur_tag = "R7";
    wr(6'h02, 32'hF);
    wr(6'h11, 32'h7FFE);
    for (int k = 0; k < 3; k++) cyc(4'b0010, 1'b0, 1'b0, 6'h01, '0);
    rd(6'h11);
    wr(6'h13, 32'hFFFF);
    wr(6'h23, 32'h1);
    cyc(4'b1000, 1'b0, 1'b0, 6'h13, '0);
    rd(6'h01);

    // R8 write-one-to-clear, set beats clear
    cur_tag = "R8";
    wr(6'h01, 32'h0);
    rd(6'h01);
    wr(6'h01, 32'h2);
    rd(6'h01);
    wr(6'h10, 32'h7FFF);
    wr(6'h20, 32'h1);
    cyc(4'b0001, 1'b0, 1'b1, 6'h01, 32'h1);
    rd(6'h01);

    // R9 mask gates the shared request
    cur_tag = "R9";
    wr(6'h02, 32'h0);
    rd(6'h01);
    wr(6'h02, 32'h1);
    rd(6'h01);
    wr(6'h01, 32'hF);
    rd(6'h01);

    // R10 unmapped space
    cur_tag = "R10";
    wr(6'h3F, 32'hFFFF_FFFF);
    rd(6'h3F); rd(6'h14); rd(6'h05); rd(6'h00);
    cur_tag = "";

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      logic [5:0] a;
      logic [DW-1:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 6'h00;
        1: a = 6'h01;
        2: a = 6'h02;
        3, 4: a = 6'(6'h10 + 6'($urandom_range(0, N-1)));
        5, 6: a = 6'(6'h20 + 6'($urandom_range(0, N-1)));
        7: a = 6'h3F;
        default: a = 6'(6'h10 + 6'($urandom_range(0, N)));
      endcase
      d = $urandom();
      if (a >= 6'h10 && a < 6'h14 && $urandom_range(0, 2) != 0)
        d = 32'h7FFC + 32'($urandom_range(0, 3));
      cyc(N'($urandom()), ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0), a, d);
    end

    rd(6'h00);
    @(negedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule